// File: doc/BRIEF.md
# Reloadable Integer Clock Divider

This block produces a divided peripheral clock from the parent clock. A small register port lets software change the divide ratio safely. The new ratio is first written to a staging field. Writing it there changes nothing on its own. The ratio takes effect only when a control write sets the clock's arm bit and the global reload bit together. The request then waits, and is reported as pending, until the divided period that is running ends. The counter switches over on that boundary, so no shortened or stretched pulse appears on the output.

Only the ratios 4, 5, 6 and 8 are ever used. A staged value outside that set is snapped to the nearest member when it is loaded. An enable bit in the control word gates the output low while the counter keeps running. Software may clear the reload bits after a reload without disturbing the ratio that is already active.

Top module: `clkdiv_reload`

## Requirements
- R1: After reset the control word (address 0x0) reads 0x0200_0000, meaning only the enable bit 25 is set. The ratio word (address 0x8) reads 0x0004_0400: staged field 4, active field 4, pending bit clear.
- R2: In the ratio word, bits [13:8] read back the staged value last written, bits [21:16] read the active ratio, bit 31 reads the pending flag, and every other bit reads 0. The control word reads back all 32 bits last written.
- R3: A reload request is a write to address 0x0 whose data has both bit 1 (arm) and bit 8 (reload) set. A write with only one of the two leaves the pending flag and the active ratio unchanged.
- R4: On a reload the staged value s is legalised: s < 4 gives 4, 4 <= s <= 6 gives s, and s >= 7 gives 8. The active ratio is always one of 4, 5, 6 or 8.
- R5: The pending flag reads 1 in the cycle after a reload request. The new ratio is applied, and the flag cleared, only at the end of a divided period. While the output is enabled, every high run and every low run lasts 2 to 4 parent cycles, even across a ratio change.
- R6: With active ratio N, the output period is N parent cycles: high for floor(N/2) cycles, then low for the rest.
- R7: While control bit 25 is 0 the output stays low, starting no later than the second cycle after the write. Setting the bit again restores the waveform of R6.
- R8: Clearing the control word after a reload, and rewriting the staged field without a reload request, leave the active ratio and the output waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register byte address (0x0 control, 0x8 ratio) |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| div_clk | output | 1 | Divided, gated clock output |

## Verification
The hardest case is a reload request that lands close to the end of a period. The switch must wait for the boundary, and no run of the output may come out short. From the ports, the phase of the divider at the moment of the request is hard to choose. So the random loop fires many requests with random staged values, and the random clearing writes fall at varied phases. A free-running monitor measures every high and low run while the output is enabled. After each reload, the first full period that follows is checked against the legalised ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // Legalise a requested ratio onto the supported set.
   function automatic int unsigned snap_ratio(input int unsigned req,
                                              input int unsigned lo,
                                              input int unsigned hi_direct,
                                              input int unsigned hi_snap);
      if (req < lo)
         return lo;
      else if (req > hi_direct)
         return hi_snap;
      else
         return req;
   endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned RATIO_W     = 6,
   parameter int unsigned CTRL_ADDR   = 0,
   parameter int unsigned RATIO_ADDR  = 8,
   parameter int unsigned ARM_BIT     = 1,
   parameter int unsigned TRIG_BIT    = 8,
   parameter int unsigned EN_BIT      = 25,
   parameter int unsigned STAGE_LSB   = 8,
   parameter int unsigned ACTIVE_LSB  = 16,
   parameter int unsigned PEND_BIT    = 31,
   parameter int unsigned RESET_RATIO = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [RATIO_W-1:0] active_ratio,
   input  logic               pending,
   output logic [RATIO_W-1:0] staged,
   output logic               out_en,
   output logic               reload_req
);
   localparam logic [DATA_W-1:0] CTRL_RESET = DATA_W'(1) << EN_BIT;

   generate
      if (EN_BIT >= DATA_W || ARM_BIT >= DATA_W || TRIG_BIT >= DATA_W)
         $error("control bit position outside the data word");
      if (STAGE_LSB + RATIO_W > ACTIVE_LSB || ACTIVE_LSB + RATIO_W > PEND_BIT)
         $error("ratio word fields overlap");
      if (PEND_BIT >= DATA_W)
         $error("pending bit outside the data word");
      if (CTRL_ADDR == RATIO_ADDR || RATIO_ADDR >= (1 << ADDR_W))
         $error("register addresses clash or do not fit");
   endgenerate

   logic [DATA_W-1:0]  ctrl_q;
   logic [RATIO_W-1:0] stage_q;

   wire ctrl_hit  = (addr == ADDR_W'(CTRL_ADDR));
   wire ratio_hit = (addr == ADDR_W'(RATIO_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RESET;
         stage_q <= RATIO_W'(RESET_RATIO);
      end else if (wr_en) begin
         if (ctrl_hit)
            ctrl_q <= wr_data;
         if (ratio_hit)
            stage_q <= wr_data[STAGE_LSB +: RATIO_W];
      end
   end

   assign reload_req = wr_en && ctrl_hit && wr_data[ARM_BIT] && wr_data[TRIG_BIT];
   assign staged     = stage_q;
   assign out_en     = ctrl_q[EN_BIT];

   always_comb begin
      rd_data = '0;
      if (ctrl_hit) begin
         rd_data = ctrl_q;
      end else if (ratio_hit) begin
         rd_data[STAGE_LSB +: RATIO_W]  = stage_q;
         rd_data[ACTIVE_LSB +: RATIO_W] = active_ratio;
         rd_data[PEND_BIT]              = pending;
      end
   end

   // R3: a request needs arm and reload in one control write
   a_r3_req_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |-> (wr_data[ARM_BIT] && wr_data[TRIG_BIT] && ctrl_hit));

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
   import clkdiv_pkg::*;
#(
   parameter int unsigned RATIO_W     = 6,
   parameter int unsigned MIN_RATIO   = 4,
   parameter int unsigned MAX_DIRECT  = 6,
   parameter int unsigned SNAP_RATIO  = 8,
   parameter int unsigned RESET_RATIO = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reload_req,
   input  logic [RATIO_W-1:0] staged,
   output logic [RATIO_W-1:0] active,
   output logic [RATIO_W-1:0] cnt,
   output logic               pending
);
   generate
      if (MIN_RATIO < 2)
         $error("ratios below 2 cannot give a high and a low phase");
      if (SNAP_RATIO >= (1 << RATIO_W) || SNAP_RATIO <= MAX_DIRECT)
         $error("snap ratio must exceed the direct range and fit the field");
      if (RESET_RATIO < MIN_RATIO || RESET_RATIO > MAX_DIRECT)
         $error("reset ratio must be a directly supported ratio");
   endgenerate

   logic [RATIO_W-1:0] cnt_q, active_q, pend_ratio_q;
   logic               pend_q;
   logic [RATIO_W-1:0] snapped;

   assign snapped = RATIO_W'(snap_ratio(32'(staged), MIN_RATIO, MAX_DIRECT, SNAP_RATIO));

   wire last = (cnt_q == active_q - RATIO_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q        <= '0;
         active_q     <= RATIO_W'(RESET_RATIO);
         pend_ratio_q <= RATIO_W'(RESET_RATIO);
         pend_q       <= 1'b0;
      end else begin
         cnt_q <= last ? '0 : cnt_q + RATIO_W'(1);
         if (reload_req) begin
            // newest request wins; it is applied at a later boundary
            pend_q       <= 1'b1;
            pend_ratio_q <= snapped;
         end else if (last && pend_q) begin
            active_q <= pend_ratio_q;
            pend_q   <= 1'b0;
         end
      end
   end

   assign active  = active_q;
   assign cnt     = cnt_q;
   assign pending = pend_q;

   // R4: divider only ever runs at a supported ratio
   a_r4_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q >= RATIO_W'(MIN_RATIO)) &&
      ((active_q <= RATIO_W'(MAX_DIRECT)) || (active_q == RATIO_W'(SNAP_RATIO))));

   // R5: ratio changes only where a period ended
   a_r5_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_q) |-> $past(last));

   // R5: pending drops exactly when its ratio is installed
   a_r5_pend_clears_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> ($past(last) && active_q == $past(pend_ratio_q)));

   // R3: pending only rises from a request
   a_r3_pend_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(reload_req));

endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out #(
   parameter int unsigned RATIO_W = 6,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               out_en,
   input  logic [RATIO_W-1:0] cnt,
   input  logic [RATIO_W-1:0] active,
   output logic               div_clk
);
   logic high_phase;
   assign high_phase = out_en && (cnt < (active >> 1));

   generate
      if (OUT_REG) begin : g_reg
         logic out_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               out_q <= 1'b0;
            else
               out_q <= high_phase;
         end
         assign div_clk = out_q;

         // R7: a cleared enable forces the output low one cycle later
         a_r7_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en |=> !div_clk);
      end else begin : g_comb
         assign div_clk = high_phase;
      end
   endgenerate

endmodule

// File: rtl/clkdiv_reload.sv
module clkdiv_reload #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned RATIO_W     = 6,
   parameter int unsigned FIELD_BIT   = 1,
   parameter int unsigned EN_SHIFT    = 24,
   parameter int unsigned TRIG_BIT    = 8,
   parameter int unsigned RATIO_ADDR  = 8,
   parameter int unsigned STAGE_LSB   = 8,
   parameter int unsigned MIN_RATIO   = 4,
   parameter int unsigned MAX_DIRECT  = 6,
   parameter int unsigned SNAP_RATIO  = 8,
   parameter int unsigned RESET_RATIO = 4,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              div_clk
);
   localparam int unsigned EN_BIT     = FIELD_BIT + EN_SHIFT;
   localparam int unsigned ACTIVE_LSB = STAGE_LSB + 8;
   localparam int unsigned PEND_BIT   = DATA_W - 1;

   logic [RATIO_W-1:0] staged, active, cnt;
   logic               pending, out_en, reload_req;

   clkdiv_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W),
      .CTRL_ADDR(0), .RATIO_ADDR(RATIO_ADDR),
      .ARM_BIT(FIELD_BIT), .TRIG_BIT(TRIG_BIT), .EN_BIT(EN_BIT),
      .STAGE_LSB(STAGE_LSB), .ACTIVE_LSB(ACTIVE_LSB), .PEND_BIT(PEND_BIT),
      .RESET_RATIO(RESET_RATIO)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data),
      .active_ratio(active), .pending(pending),
      .staged(staged), .out_en(out_en), .reload_req(reload_req)
   );

   clkdiv_core #(
      .RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO), .MAX_DIRECT(MAX_DIRECT),
      .SNAP_RATIO(SNAP_RATIO), .RESET_RATIO(RESET_RATIO)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .reload_req(reload_req), .staged(staged),
      .active(active), .cnt(cnt), .pending(pending)
   );

   clkdiv_out #(
      .RATIO_W(RATIO_W), .OUT_REG(OUT_REG)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .out_en(out_en), .cnt(cnt),
      .active(active), .div_clk(div_clk)
   );

endmodule

// File: tb/clkdiv_reload_bench.sv
module clkdiv_reload_bench;
   localparam logic [31:0] EN   = 32'h0200_0000;
   localparam logic [31:0] ARM  = 32'h0000_0002;
   localparam logic [31:0] TRIG = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   wire  [31:0] rd_data;
   wire         div_clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   clkdiv_reload u_clkdiv_reload (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .div_clk(div_clk)
   );

   function automatic int snap(input int r);
      if (r < 4) return 4;
      if (r > 6) return 8;
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rd_data;
   endtask

   // run monitor: every full high/low run while enabled must last 2..4 cycles (R5)
   bit   mon_on = 1'b0;
   int   runt_bad = 0;
   int   run = 0;
   logic last_lvl = 1'b0;
   always @(negedge clk) begin
      if (!mon_on) begin
         run = 0;
         last_lvl = div_clk;
      end else if (div_clk == last_lvl) begin
         if (run != 0) run++;
      end else begin
         if (run != 0 && (run < 2 || run > 4)) runt_bad++;
         run = 1;
         last_lvl = div_clk;
      end
   end

   task automatic measure(output int hi, output int lo);
      logic prev;
      prev = div_clk;
      hi = 0; lo = 0;
      for (int g = 0; g < 200; g++) begin
         @(negedge clk);
         if (div_clk && !prev) break;
         prev = div_clk;
      end
      hi = 1;
      for (int g = 0; g < 200; g++) begin
         @(negedge clk);
         if (div_clk) hi++; else break;
      end
      lo = 1;
      for (int g = 0; g < 200; g++) begin
         @(negedge clk);
         if (!div_clk) lo++; else break;
      end
   endtask

   task automatic check_wave(input string req, input int n);
      int hi, lo;
      measure(hi, lo);
      chk({req, " high cycles"}, hi, n / 2);
      chk({req, " low cycles"}, lo, n - n / 2);
   endtask

   task automatic wait_applied;
      logic [31:0] d;
      for (int g = 0; g < 100; g++) begin
         @(negedge clk);
         rd(4'h8, d);
         if (!d[31]) break;
      end
   endtask

   task automatic reload(input int r);
      logic [31:0] d;
      wr(4'h8, 32'(r) << 8);
      wr(4'h0, EN | ARM);
      wr(4'h0, EN | ARM | TRIG);
      rd(4'h8, d);
      chk("R5 pending after request", 32'(d[31]), 32'd1);
      wr(4'h0, EN);                      // clear arm and reload (R8)
      wait_applied();
      rd(4'h8, d);
      chk("R4 active after reload", 32'(d[21:16]), 32'(snap(r)));
      chk("R5 pending cleared", 32'(d[31]), 32'd0);
   endtask

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, d);
      chk("R1 control reset", d, 32'h0200_0000);
      rd(4'h8, d);
      chk("R1 ratio reset", d, 32'h0004_0400);
      check_wave("R1 R6 reset ratio 4", 4);
      mon_on = 1'b1;

      // R4 R6 directed ratios
      reload(5); check_wave("R6 ratio 5", 5);
      reload(0); check_wave("R4 ratio 0 to 4", 4);
      reload(63); check_wave("R4 ratio 63 to 8", 8);
      reload(7); check_wave("R4 ratio 7 to 8", 8);
      reload(6); check_wave("R6 ratio 6", 6);

      // R3 trigger alone, then arm alone
      wr(4'h8, 32'd5 << 8);
      wr(4'h0, EN | TRIG);
      rd(4'h8, d);
      chk("R3 reload without arm pending", 32'(d[31]), 32'd0);
      wr(4'h0, EN | ARM);
      rd(4'h8, d);
      chk("R3 arm without reload pending", 32'(d[31]), 32'd0);
      repeat (20) @(negedge clk);
      rd(4'h8, d);
      chk("R3 active unchanged", 32'(d[21:16]), 32'd6);
      check_wave("R3 waveform unchanged", 6);
      wr(4'h0, EN);

      // R2 readback with stray bits in the ratio write
      wr(4'h8, 32'hFFFF_C5FF);
      rd(4'h8, d);
      chk("R2 ratio word readback", d, 32'h0006_0500);
      wr(4'h0, 32'h0200_00A5);
      rd(4'h0, d);
      chk("R2 control word readback", d, 32'h0200_00A5);

      // R8 clear and staged rewrite leave the active ratio alone
      reload(4);
      wr(4'h8, 32'd8 << 8);
      wr(4'h0, EN);
      repeat (12) @(negedge clk);
      rd(4'h8, d);
      chk("R8 active kept after clear", 32'(d[21:16]), 32'd4);
      chk("R8 staged rewritten", 32'(d[13:8]), 32'd8);
      check_wave("R8 waveform kept", 4);

      // R7 disable and re-enable
      mon_on = 1'b0;
      wr(4'h0, 32'd0);
      @(negedge clk);
      begin
         int seen_high = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_clk) seen_high++;
         end
         chk("R7 output low while disabled", 32'(seen_high), 32'd0);
      end
      wr(4'h0, EN);
      check_wave("R7 resumed waveform", 4);
      mon_on = 1'b1;

      // random reloads, cleared at random phases (R4 R5 R6)
      for (int it = 0; it < 16; it++) begin
         int r;
         r = int'($urandom % 64);
         repeat (int'($urandom % 5)) @(negedge clk);
         reload(r);
         check_wave("R6 random ratio", snap(r));
      end

      chk("R5 no runt runs", 32'(runt_bad), 32'd0);

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule